// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target side of a two-wire serial memory. It watches a clock line and a data line that are sampled by a faster system clock. It recognises start and stop conditions on the bus and moves 8-bit words in both directions, most significant bit first. It pulls the shared data line low through an open-drain enable, both for acknowledge bits and for read data.

A transfer opens with a device address byte. For a write, the next two bytes load the word pointer and any further bytes are stored in a small on-chip byte array. A stop that follows at least one data byte starts a timed internal write cycle. For a read, the target returns bytes from the pointer onward for as long as the controller keeps acknowledging. A random read is a write that carries only the pointer bytes, followed by a repeated start and a read.

Top module: `serial_eeprom_target`

## Requirements
- R1: Out of reset `sda_drive_low` is 0. Until a start condition is seen, the target ignores bus activity and drives nothing.
- R2: The device address byte is 1010, then the three select bits `DEV_SEL`, then the direction bit (1 = read). A byte that matches is acknowledged by holding SDA low for the whole ninth SCL clock. A byte that does not match gets no acknowledge, and the target then ignores the bus until the next start.
- R3: In a write, the target acknowledges each of the two pointer bytes (high byte first) and every data byte. The low `MEM_AW` bits of the 14-bit pointer select the cell in the array.
- R4: Each data byte written increments only the low `PAGE_AW` bits of the pointer, so successive writes wrap within the same 64-byte page.
- R5: A stop that follows at least one data byte starts a write cycle lasting `TWC_CYCLES` system clocks. During that cycle the target does not acknowledge its device address and drives nothing. After the cycle it acknowledges again.
- R6: After it acknowledges a read device address, the target sends the byte at the pointer, MSB first. Each bit is changed only while SCL is low.
- R7: When the controller acknowledges a read byte with 0, the pointer increments and the next byte is sent. The increment wraps from the last array cell to cell 0.
- R8: When the controller answers 1 after a read byte, the target releases SDA and sends no further data until a start or stop. A stop returns it to standby.
- R9: A start seen in the middle of a transfer resets the byte state machine, and the next byte is taken as a new device address.
- R10: A write that ends with a stop after only the pointer bytes, with no data bytes, does not start a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench writes across the end of a page and reads across the end of the array. A design that used one increment rule for both would store the third byte outside its page, or read a wrong cell after the last one. It polls the device address straight after a write stop, and again after a stop that followed only pointer bytes. A timer that is missing, or that starts on the wrong stop, shows up as an acknowledge that is present or absent in the wrong place. It also keeps clocking after a read NACK with no stop, sends a device address with the wrong select bits followed by a further byte, and restarts in the middle of a write. A target that kept transmitting, or that acknowledged bytes it should ignore, would pull the bus low where the scoreboard expects ones.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } bus_state_t;

    typedef enum logic [1:0] {
        ROLE_DEV,
        ROLE_AHI,
        ROLE_ALO,
        ROLE_DATA
    } byte_role_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_TYPE_CODE) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync
    import eep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic                   scl_p;
    logic                   sda_p;
    logic                   scl_s;
    logic                   sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
            scl_p <= scl_q[TOP];
            sda_p <= sda_q[TOP];
        end
    end

    assign scl_s = scl_q[TOP];
    assign sda_s = sda_q[TOP];

    always_comb begin
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
    parameter int TWC_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(TWC_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(TWC_CYCLES);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (kick) begin
            remain <= LOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
    import eep_pkg::*;
#(
    parameter int         MEM_AW      = 8,
    parameter int         PAGE_AW     = 6,
    parameter int         PTR_W       = 14,
    parameter int         TWC_CYCLES  = 5000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] DEV_SEL     = 3'b000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_drive_low
);
    localparam logic [PTR_W-1:0] PAGE_MASK = PTR_W'((1 << PAGE_AW) - 1);
    localparam logic [PTR_W-1:0] ARR_MASK  = PTR_W'((1 << MEM_AW) - 1);
    localparam logic [PTR_W-1:0] PTR_ONE   = PTR_W'(1);

    line_ev_t    ev;
    bus_state_t  st;
    byte_role_t  role;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic [PTR_W-1:0] ptr;
    logic        rd_mode;
    logic        wr_pending;
    logic        host_ack;
    logic        sda_low;
    logic        wc_busy;
    logic        wc_kick;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic        byte_done;
    logic [PTR_W-1:0] ptr_page_next;
    logic [PTR_W-1:0] ptr_arr_next;

    eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    eep_array #(.AW(MEM_AW)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (ptr[MEM_AW-1:0]),
        .wdata (shreg),
        .raddr (ptr[MEM_AW-1:0]),
        .rdata (mem_rdata)
    );

    eep_write_timer #(.TWC_CYCLES(TWC_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .kick (wc_kick),
        .busy (wc_busy)
    );

    assign ptr_page_next = (ptr & ~PAGE_MASK) | ((ptr + PTR_ONE) & PAGE_MASK);
    assign ptr_arr_next  = (ptr & ~ARR_MASK)  | ((ptr + PTR_ONE) & ARR_MASK);

    assign byte_done = (st == ST_RX) && ev.scl_fall && (bitcnt == 4'd8)
                       && !ev.start && !ev.stop;
    assign mem_we    = byte_done && (role == ROLE_DATA);
    assign wc_kick   = ev.stop && wr_pending;
    assign sda_drive_low = sda_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            role       <= ROLE_DEV;
            bitcnt     <= '0;
            shreg      <= '0;
            ptr        <= '0;
            rd_mode    <= 1'b0;
            wr_pending <= 1'b0;
            host_ack   <= 1'b0;
            sda_low    <= 1'b0;
        end else if (ev.start) begin
            st         <= ST_RX;
            role       <= ROLE_DEV;
            bitcnt     <= '0;
            rd_mode    <= 1'b0;
            wr_pending <= 1'b0;
            sda_low    <= 1'b0;
        end else if (ev.stop) begin
            st         <= ST_IDLE;
            wr_pending <= 1'b0;
            sda_low    <= 1'b0;
        end else begin
            unique case (st)
                ST_RX: begin
                    if (ev.scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        unique case (role)
                            ROLE_DEV: begin
                                if (dev_match(shreg, DEV_SEL) && !wc_busy) begin
                                    sda_low <= 1'b1;
                                    st      <= ST_RX_ACK;
                                    rd_mode <= shreg[0];
                                    role    <= ROLE_AHI;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            ROLE_AHI: begin
                                ptr     <= PTR_W'({shreg, ptr[7:0]});
                                role    <= ROLE_ALO;
                                sda_low <= 1'b1;
                                st      <= ST_RX_ACK;
                            end
                            ROLE_ALO: begin
                                ptr[7:0] <= shreg;
                                role     <= ROLE_DATA;
                                sda_low  <= 1'b1;
                                st       <= ST_RX_ACK;
                            end
                            ROLE_DATA: begin
                                ptr        <= ptr_page_next;
                                wr_pending <= 1'b1;
                                sda_low    <= 1'b1;
                                st         <= ST_RX_ACK;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (rd_mode) begin
                            shreg   <= mem_rdata;
                            sda_low <= ~mem_rdata[7];
                            st      <= ST_TX;
                        end else begin
                            sda_low <= 1'b0;
                            st      <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_low <= 1'b0;
                            bitcnt  <= '0;
                            st      <= ST_TX_ACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            sda_low <= ~shreg[6];
                            bitcnt  <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise) begin
                        host_ack <= ~ev.sda;
                        if (!ev.sda) ptr <= ptr_arr_next;
                    end else if (ev.scl_fall) begin
                        if (host_ack) begin
                            shreg   <= mem_rdata;
                            sda_low <= ~mem_rdata[7];
                            st      <= ST_TX;
                        end else begin
                            st <= ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eep_target_chk.sv
module eep_target_chk
    import eep_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_in,
    input logic       sda_drive_low,
    input logic       wc_busy,
    input bus_state_t st,
    input logic       ev_start
);
    // R1
    reset_release_chk: assert property (@(posedge clk) rst |=> !sda_drive_low);

    // R6
    drive_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $changed(sda_drive_low) |-> !scl_in);

    // R5
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wc_busy |-> !sda_drive_low);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wc_busy) |=> wc_busy);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_drive_low);

    // R9
    start_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (st == ST_RX));
endmodule

bind serial_eeprom_target eep_target_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_in        (scl_in),
    .sda_drive_low (sda_drive_low),
    .wc_busy       (wc_busy),
    .st            (st),
    .ev_start      (ev.start)
);

// File: tb/tb_serial_eeprom_target.sv
module tb_serial_eeprom_target;
    localparam int CLK_P = 10;
    localparam int TWC   = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_drive_low;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    assign sda_bus = m_sda & ~sda_drive_low;

    serial_eeprom_target #(.TWC_CYCLES(TWC)) dut (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (m_scl),
        .sda_in        (sda_bus),
        .sda_drive_low (sda_drive_low)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bstart();
        m_scl = 1'b0; tick(4);
        m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic bstop();
        m_scl = 1'b0;
        m_sda = 1'b0; tick(4);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(6);
            m_scl = 1'b1; tick(8);
            m_scl = 1'b0; tick(2);
        end
        m_sda = 1'b1; tick(6);
        m_scl = 1'b1; tick(4);
        acked = (sda_bus == 1'b0);
        tick(4);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(6);
            m_scl = 1'b1; tick(4);
            b[i] = sda_bus;
            tick(4);
            m_scl = 1'b0; tick(2);
        end
        m_sda = ~give_ack; tick(6);
        m_scl = 1'b1; tick(8);
        m_scl = 1'b0; tick(2);
        m_sda = 1'b1;
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic read_into_sb(input logic give_ack);
        logic [7:0] b;
        recv_byte(give_ack, b);
        got_q.push_back(b);
    endtask

    task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
        logic a;
        bstart();
        send_byte(8'hA0, a); check(a, tag, a, 1);
        send_byte(hi, a);    check(a, "R3", a, 1);
        send_byte(lo, a);    check(a, "R3", a, 1);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0) begin
                logic [7:0] g;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "scoreboard-empty", g, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(g == e, t, g, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        tick(5);
        rst = 1'b0;
        tick(3);
        check(sda_drive_low == 1'b0, "R1", sda_drive_low, 0);

        // R1: traffic with no start is ignored
        m_scl = 1'b0; tick(4);
        send_byte(8'hA0, a);
        check(!a, "R1", a, 0);
        bstop();

        // R2 R3: page write of three bytes at 0x0010
        set_ptr(8'h00, 8'h10, "R2");
        send_byte(8'h11, a); check(a, "R3", a, 1);
        send_byte(8'h22, a); check(a, "R3", a, 1);
        send_byte(8'h33, a); check(a, "R3", a, 1);
        bstop();

        // R5: busy during the write cycle
        bstart();
        send_byte(8'hA0, a); check(!a, "R5", a, 0);
        bstop();
        tick(TWC + 20);
        bstart();
        send_byte(8'hA0, a); check(a, "R5", a, 1);
        bstop();

        // R6 R7 R8: random read of three bytes, then NACK
        set_ptr(8'h00, 8'h10, "R6");
        bstart();
        send_byte(8'hA1, a); check(a, "R6", a, 1);
        expect_byte(8'h11, "R6");
        expect_byte(8'h22, "R7");
        expect_byte(8'h33, "R7");
        read_into_sb(1'b1);
        read_into_sb(1'b1);
        read_into_sb(1'b0);
        recv_byte(1'b0, d);
        check(d == 8'hFF, "R8", d, 8'hFF);
        check(sda_drive_low == 1'b0, "R8", sda_drive_low, 0);
        bstop();
        bstart();
        send_byte(8'hA0, a); check(a, "R8", a, 1);
        bstop();

        // R10: pointer-only write starts no cycle
        set_ptr(8'h00, 8'h20, "R10");
        bstop();
        bstart();
        send_byte(8'hA0, a); check(a, "R10", a, 1);
        bstop();

        // R4: page wrap at 0x003E
        set_ptr(8'h00, 8'h3E, "R4");
        send_byte(8'hAA, a); check(a, "R4", a, 1);
        send_byte(8'hBB, a); check(a, "R4", a, 1);
        send_byte(8'hCC, a); check(a, "R4", a, 1);
        bstop();
        tick(TWC + 20);
        set_ptr(8'h00, 8'h3E, "R4");
        bstart();
        send_byte(8'hA1, a); check(a, "R4", a, 1);
        expect_byte(8'hAA, "R4");
        expect_byte(8'hBB, "R4");
        read_into_sb(1'b1);
        read_into_sb(1'b0);
        bstop();
        set_ptr(8'h00, 8'h00, "R4");
        bstart();
        send_byte(8'hA1, a); check(a, "R4", a, 1);
        expect_byte(8'hCC, "R4");
        read_into_sb(1'b0);
        bstop();

        // R7: read wraps at end of array
        set_ptr(8'h00, 8'hFF, "R7");
        send_byte(8'h5A, a); check(a, "R7", a, 1);
        bstop();
        tick(TWC + 20);
        set_ptr(8'h00, 8'hFF, "R7");
        bstart();
        send_byte(8'hA1, a); check(a, "R7", a, 1);
        expect_byte(8'h5A, "R7");
        expect_byte(8'hCC, "R7");
        read_into_sb(1'b1);
        read_into_sb(1'b0);
        bstop();

        // R2: wrong select bits, then further bytes ignored
        bstart();
        send_byte(8'hA2, a); check(!a, "R2", a, 0);
        send_byte(8'h00, a); check(!a, "R2", a, 0);
        bstop();

        // R9: restart in the middle of a write
        bstart();
        send_byte(8'hA0, a); check(a, "R9", a, 1);
        send_byte(8'h00, a); check(a, "R9", a, 1);
        bstart();
        send_byte(8'hA1, a); check(a, "R9", a, 1);
        expect_byte(8'hCC, "R9");
        read_into_sb(1'b0);
        bstop();

        tick(20);
        check(exp_q.size() == 0, "scoreboard-drain", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule